// File: doc/BRIEF.md
# Most-Significant-One Scan Unit

This execution unit reports where the highest 1 bit of a source operand sits. The operand is 16, 32 or 64 bits wide, and the width is picked separately for every operation by a two-bit size code. The 64-bit source, the size code and the current destination value all arrive together with a valid strobe. One clock later the unit presents the following:

- the bit index, zero-extended to 64 bits;
- a zero flag;
- a destination write-enable;
- five auxiliary arithmetic flags, which are always held at 0.

When the examined part of the source holds no 1, the unit sets the zero flag and drops the write-enable. It also passes the old destination value through on the result port, so the destination keeps its contents whether or not the caller honours the enable. Bits above the selected width have no effect. A leading-one tree of log depth does the search, so the whole scan fits inside one clock.

The output stage is a two-state machine:

- **ST_IDLE**: no result is presented.
- **ST_RESULT**: a result is on the outputs for exactly one cycle.

The transitions are:

- **accept**: ST_IDLE to ST_RESULT when `in_valid` is 1.
- **stream**: ST_RESULT to ST_RESULT when `in_valid` is 1.
- **drain**: ST_RESULT to ST_IDLE when `in_valid` is 0.
- **wait**: ST_IDLE to ST_IDLE when `in_valid` is 0.

Reset forces ST_IDLE.

Top module: `msb_scan_unit`

## Requirements
- R1: For a non-zero examined operand, `result` is the unsigned position (counting from bit 0) of the highest 1 bit within the selected width, and `result[63:6]` is 0.
- R2: `size_code` 2'b00 selects 16 bits, 2'b01 selects 32 bits, 2'b10 selects 64 bits, and the unused code 2'b11 behaves as 32 bits.
- R3: With a 16- or 32-bit size, source bits at or above that width do not affect `result`, `zero_flag` or `dest_we`. An operand that is zero within the width counts as zero even if higher bits are set.
- R4: When the examined operand is zero, `zero_flag` is 1, `dest_we` is 0 and `result` equals the `old_dest` that was sampled with the operation.
- R5: When the examined operand is non-zero, `zero_flag` is 0 and `dest_we` is 1.
- R6: `carry_flag`, `ovf_flag`, `sign_flag`, `aux_flag` and `parity_flag` are always 0.
- R7: `out_valid` is 1 exactly in the cycle after a cycle with `in_valid` at 1, and `dest_we` is 0 whenever `out_valid` is 0. Back-to-back operations give one result per cycle.
- R8: While reset (`rst_n` low) is held, `out_valid`, `dest_we`, `zero_flag` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation presented this cycle |
| src | input | 64 | Source operand |
| size_code | input | 2 | Operand width select (00=16, 01=32, 10=64, 11=32) |
| old_dest | input | 64 | Current destination contents |
| out_valid | output | 1 | Result presented this cycle |
| result | output | 64 | Bit index, or old destination when the operand is zero |
| zero_flag | output | 1 | Examined operand was zero |
| dest_we | output | 1 | Destination should be written |
| carry_flag | output | 1 | Held at 0 |
| ovf_flag | output | 1 | Held at 0 |
| sign_flag | output | 1 | Held at 0 |
| aux_flag | output | 1 | Held at 0 |
| parity_flag | output | 1 | Held at 0 |

## Verification
For every width, the bench walks a single leading one through every position and fills random bits below it. This exposes any index bit of the tree that is wrong or stuck, and it shows whether lower ones ever leak into the answer. Garbage placed only above a 16- or 32-bit width, plus the spare size code, separates correct masking from a scan over the wrong width. Zero operands paired with random old destinations show whether the pass-through and the enable drop are both in effect. Random streams with idle gaps mixed in separate back-to-back throughput from single-cycle latency.

// File: rtl/msb_pkg.sv
package msb_pkg;

    typedef enum logic [1:0] {
        SZ_16  = 2'b00,
        SZ_32  = 2'b01,
        SZ_64  = 2'b10,
        SZ_SPR = 2'b11
    } op_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } out_state_e;

    // Number of operand bits examined for a size code; the spare code maps to 32.
    function automatic int unsigned scan_width(input op_size_e sz);
        unique case (sz)
            SZ_16:   scan_width = 16;
            SZ_64:   scan_width = 64;
            default: scan_width = 32;
        endcase
    endfunction

endpackage

// File: rtl/msb_width_mask.sv
module msb_width_mask #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]    src,
    input  msb_pkg::op_size_e    size,
    output logic [DATA_W-1:0]    masked
);
    int unsigned width;

    always_comb begin
        width = msb_pkg::scan_width(size);
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = src[i] & (32'(i) < width);
        end
    end

endmodule

// File: rtl/msb_lead_one.sv
module msb_lead_one #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] pos
);
    // Pairwise reduction tree, reused in place level by level.
    logic [W-1:0]  hit;
    logic [IW-1:0] idx [W];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            hit[i] = vec[i];
            idx[i] = '0;
        end
        for (int lvl = 1; lvl <= IW; lvl++) begin
            for (int n = 0; n < (W >> lvl); n++) begin
                if (hit[2*n+1]) begin
                    idx[n] = idx[2*n+1] | (IW'(1) << (lvl - 1));
                end else begin
                    idx[n] = idx[2*n];
                end
                hit[n] = hit[2*n] | hit[2*n+1];
            end
        end
        found = hit[0];
        pos   = idx[0];
    end

endmodule

// File: rtl/msb_scan_unit.sv
module msb_scan_unit #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src,
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] old_dest,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              zero_flag,
    output logic              dest_we,
    output logic              carry_flag,
    output logic              ovf_flag,
    output logic              sign_flag,
    output logic              aux_flag,
    output logic              parity_flag
);
    import msb_pkg::*;

    localparam int IDX_W = $clog2(DATA_W);

    op_size_e          size;
    logic [DATA_W-1:0] examined;
    logic              any_one;
    logic [IDX_W-1:0]  top_pos;
    logic [DATA_W-1:0] nxt_result;

    out_state_e        state_q, state_d;
    logic [DATA_W-1:0] result_q;
    logic              zero_q;

    assign size = op_size_e'(size_code);

    msb_width_mask #(.DATA_W(DATA_W)) u_mask (
        .src    (src),
        .size   (size),
        .masked (examined)
    );

    msb_lead_one #(.W(DATA_W), .IW(IDX_W)) u_tree (
        .vec   (examined),
        .found (any_one),
        .pos   (top_pos)
    );

    assign nxt_result = any_one ? DATA_W'(top_pos) : old_dest;

    // Next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers, loaded on accepted operations
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            zero_q   <= 1'b0;
        end else if (in_valid) begin
            result_q <= nxt_result;
            zero_q   <= !any_one;
        end
    end

    assign out_valid   = (state_q == ST_RESULT);
    assign dest_we     = out_valid && !zero_q;
    assign result      = result_q;
    assign zero_flag   = zero_q;
    assign carry_flag  = 1'b0;
    assign ovf_flag    = 1'b0;
    assign sign_flag   = 1'b0;
    assign aux_flag    = 1'b0;
    assign parity_flag = 1'b0;

endmodule

// File: rtl/msb_scan_checker.sv
module msb_scan_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] src,
    input logic [1:0]        size_code,
    input logic [DATA_W-1:0] old_dest,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              zero_flag,
    input logic              dest_we,
    input logic              carry_flag,
    input logic              ovf_flag,
    input logic              sign_flag,
    input logic              aux_flag,
    input logic              parity_flag
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] src_seen;
    always_ff @(posedge clk) begin
        src_seen <= src;
    end

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_no_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !dest_we);
    assert_zero_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_flag) |-> !dest_we);
    assert_zero_keeps_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!zero_flag || result == $past(old_dest)));
    assert_nonzero_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !zero_flag) |-> dest_we);
    assert_index_hits_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid ##1 dest_we) |->
            (result[DATA_W-1:IDX_W] == '0 && src_seen[result[IDX_W-1:0]]));
    assert_narrow_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'b00) |=> (!dest_we || result < 16));
    assert_mid_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code[0]) |=> (!dest_we || result < 32));

    always_comb begin
        assert_flags_low_R6: assert (!(carry_flag || ovf_flag || sign_flag || aux_flag || parity_flag));
    end

endmodule

bind msb_scan_unit msb_scan_checker #(.DATA_W(DATA_W)) u_msb_scan_checker (.*);

// File: tb/test_msb_scan_unit.sv
module test_msb_scan_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] src;
    logic [1:0]  size_code;
    logic [63:0] old_dest;
    logic        out_valid;
    logic [63:0] result;
    logic        zero_flag;
    logic        dest_we;
    logic        carry_flag, ovf_flag, sign_flag, aux_flag, parity_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Expectations for the outputs after the next clock edge.
    bit          exp_v = 0;
    logic [63:0] exp_res = '0;
    bit          exp_z = 0;
    bit          exp_we = 0;
    string       exp_tag = "R7";

    msb_scan_unit i_msb_scan_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .size_code(size_code), .old_dest(old_dest), .out_valid(out_valid),
        .result(result), .zero_flag(zero_flag), .dest_we(dest_we),
        .carry_flag(carry_flag), .ovf_flag(ovf_flag), .sign_flag(sign_flag),
        .aux_flag(aux_flag), .parity_flag(parity_flag)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: downward search from the top of the chosen width.
    task automatic predict(input logic [63:0] s, input logic [1:0] sz, input logic [63:0] od);
        int w;
        int top;
        w = (sz == 2'b00) ? 16 : (sz == 2'b10) ? 64 : 32;
        top = -1;
        for (int i = w - 1; i >= 0; i--) begin
            if (s[i] && top < 0) top = i;
        end
        exp_z   = (top < 0);
        exp_we  = (top >= 0);
        exp_res = (top < 0) ? od : 64'(top);
    endtask

    task automatic compare();
        check("R7", "out_valid", 64'(out_valid), 64'(exp_v));
        check("R6", "aux flags", {59'd0, carry_flag, ovf_flag, sign_flag, aux_flag, parity_flag}, 64'd0);
        if (!exp_v) begin
            check("R7", "dest_we idle", 64'(dest_we), 64'd0);
        end else begin
            check(exp_tag, "result", result, exp_res);
            check(exp_z ? "R4" : "R5", "zero_flag", 64'(zero_flag), 64'(exp_z));
            check(exp_z ? "R4" : "R5", "dest_we", 64'(dest_we), 64'(exp_we));
        end
    endtask

    task automatic step(input bit v, input logic [63:0] s, input logic [1:0] sz,
                        input logic [63:0] od, input string tag);
        @(negedge clk);
        compare();
        in_valid  = v;
        src       = s;
        size_code = sz;
        old_dest  = od;
        exp_v     = v;
        exp_tag   = tag;
        if (v) predict(s, sz, od);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; src = '0; size_code = 2'b01; old_dest = '0;
        // R8: reset state
        repeat (3) @(negedge clk);
        check("R8", "out_valid in reset", 64'(out_valid), 64'd0);
        check("R8", "dest_we in reset", 64'(dest_we), 64'd0);
        check("R8", "zero_flag in reset", 64'(zero_flag), 64'd0);
        check("R8", "result in reset", result, 64'd0);
        rst_n = 1'b1;

        // R1: walk the leading one over all 64 positions, random ones below it
        for (int i = 0; i < 64; i++) begin
            logic [63:0] low;
            low = rnd64() & ((64'd1 << i) - 64'd1);
            step(1, (64'd1 << i) | low, 2'b10, rnd64(), "R1");
        end
        // R2: 16-bit, 32-bit and spare-code widths
        for (int i = 0; i < 16; i++) step(1, (64'd1 << i) | ($urandom & ((64'd1 << i) - 1)), 2'b00, rnd64(), "R2");
        for (int i = 0; i < 32; i++) step(1, (64'd1 << i), 2'b01, rnd64(), "R2");
        for (int i = 0; i < 32; i++) step(1, (64'd1 << i) | 64'd1, 2'b11, rnd64(), "R2");
        // R3: garbage above the selected width
        for (int i = 0; i < 16; i++) begin
            step(1, {rnd64()} & ~64'hFFFF | (64'd1 << i), 2'b00, rnd64(), "R3");
            step(1, {rnd64()} & ~64'hFFFF_FFFF | (64'd1 << (2*i+1)), 2'b01, rnd64(), "R3");
        end
        step(1, 64'hFFFF_FFFF_FFFF_0000, 2'b00, 64'h1234_5678_9ABC_DEF0, "R3");
        step(1, 64'h8000_0000_0000_0000, 2'b01, 64'h0BAD_F00D_0000_0001, "R3");
        step(1, 64'h0000_0001_0000_0000, 2'b11, 64'h5555_AAAA_5555_AAAA, "R3");
        // R4: zero operand at each width keeps the old destination
        step(1, 64'd0, 2'b10, 64'hDEAD_BEEF_CAFE_F00D, "R4");
        step(1, 64'd0, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, "R4");
        step(1, 64'd0, 2'b01, 64'd0, "R4");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, 64'd7, "R1");
        // R7: idle gaps and isolated operations
        step(0, rnd64(), 2'b10, rnd64(), "R7");
        step(1, 64'd5, 2'b10, 64'd0, "R7");
        step(0, 64'd0, 2'b10, 64'd0, "R7");
        step(0, 64'd0, 2'b10, 64'd0, "R7");
        step(1, 64'd0, 2'b10, 64'd99, "R7");
        step(0, 64'd1, 2'b10, 64'd0, "R7");
        // R5: random stream with random gaps
        for (int k = 0; k < 400; k++) begin
            logic [63:0] s;
            s = rnd64() >> ($urandom % 64);
            if ($urandom % 8 == 0) s = '0;
            step(($urandom % 4) != 0, s, 2'($urandom), rnd64(), "R5");
        end
        step(0, 64'd0, 2'b01, 64'd0, "R7");
        step(0, 64'd0, 2'b01, 64'd0, "R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule